// File: doc/BRIEF.md
# Write-Protected I2C Serial Byte Memory

This block is an I2C target that fronts a 2048-byte on-chip byte memory. A host on the two-wire bus can store a single byte or a burst of up to sixteen bytes that all fall within one aligned 16-byte page. It can read back from the internal address pointer, from an address it loads first through a dummy write, or as an open-ended stream. The block runs from a fast system clock. It oversamples SCL and SDA, removes short spikes, recognises START and STOP conditions, and signals on SDA only by pulling the line low.

Bytes that a host writes are collected in a page buffer. They are committed only when a STOP closes the write. The commit runs as a modelled program cycle of `PROG_CYCLES` clocks. During that window the target ignores the bus completely. Two conditions prevent a commit: a high level on the write-protect input, and a low level on the supply-good input. In both cases the transfer is still acknowledged as usual, but neither the memory nor the busy state changes.

Top module: `i2c_prot_eeprom`

## Requirements
- R1: The first byte after a START is the target byte: bits 7:4 must equal 4'b1010, bits 3:1 carry memory address bits 10:8, and bit 0 selects read (1) or write (0). A matching byte is acknowledged (SDA low in the ninth clock); any other byte is not, and the target then ignores the bus until the next START.
- R2: A write of a target byte, a word-address byte (address bits 7:0) and one data byte, closed by STOP, stores the data at that address once the program window ends.
- R3: Consecutive data bytes of one write go to successive addresses whose low 4 bits wrap inside the 16-byte page; past 16 bytes the newest bytes replace the earliest.
- R4: While the write-protect input is 1 at STOP, the data bytes are still acknowledged, no program window starts (the target byte is acknowledged at once), and the memory keeps its old contents.
- R5: While the supply-good input is 0 at STOP, the write behaves as in R4: acknowledged, no program window, memory unchanged.
- R6: For PROG_CYCLES clocks after a STOP that ends an allowed write, the target never pulls SDA low and does not acknowledge its target byte; after the window it acknowledges again.
- R7: A write that carries only the word address, followed by a repeated START and a read target byte, returns the byte stored at that address.
- R8: A read that starts without a word address returns the byte at the internal pointer, which points one past the last byte read.
- R9: A read delivers successive bytes while the host acknowledges, with the address stepping from 2047 to 0, and stops driving after the host leaves the ninth bit high.
- R10: SDA is only ever pulled low, only in an acknowledge slot or a read data bit, and it is released out of reset.
- R11: A pulse shorter than GLITCH_CYCLES clocks on SCL or SDA has no effect on the transfer.
- R12: A START that arrives before the STOP of a write discards the buffered data bytes: no program window, no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low |
| wp_i | input | 1 | Write protect, 1 makes the whole array read-only |
| supply_ok_i | input | 1 | Supply-good flag, 0 locks out writes |

## Verification
The hardest situation to reach from the ports is a host addressing the target while the program window is still open. The host then sees nothing but a released line. Several cases have to be told apart: a write that started a program window, one that was blocked by protection or lockout, and one that was cut short by a repeated START. To separate them, the stimulus probes the target byte in the very next transaction after every STOP. That probe must be refused after an allowed write and accepted in every other case. Random page writes with random protect and supply settings are each followed by an immediate probe and by a read-back against a bench model of the memory. Directed cases add the page overflow, the wrap from 2047 to 0 and sub-filter spikes injected into a live byte.

// File: rtl/i2c_prot_eeprom_pkg.sv
package i2c_prot_eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADDR,
    S_WDATA,
    S_ACK,
    S_RD,
    S_RACK
  } bus_state_t;
endpackage

// File: rtl/sig_filter.sv
module sig_filter #(
  parameter int CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // the output only moves after the synchronised input held a new level for CYC clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(CYC - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/mem_array.sv
module mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
    rdata <= cell_q[raddr];
  end
endmodule

// File: rtl/prog_engine.sv
module prog_engine #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] base,
  input  logic [PAGE_BYTES-1:0][7:0]          pbuf,
  input  logic [PAGE_BYTES-1:0]               pvalid,
  input  logic                                supply_ok,
  output logic                                busy,
  output logic                                we,
  output logic [ADDR_W-1:0]                   waddr,
  output logic [7:0]                          wdata
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int TW0   = $clog2(PROG_CYCLES + 1);
  localparam int TW    = (TW0 > OFS_W) ? TW0 : OFS_W + 1;

  logic [TW-1:0]    tick_q;
  logic             busy_q;
  logic [OFS_W-1:0] slot;
  logic             copy_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        tick_q <= '0;
      end
    end else begin
      if (tick_q == TW'(PROG_CYCLES - 1)) busy_q <= 1'b0;
      tick_q <= tick_q + 1'b1;
    end
  end

  // the first PAGE_BYTES clocks of the window copy one buffer slot each
  assign slot       = tick_q[OFS_W-1:0];
  assign copy_phase = busy_q && (tick_q < TW'(PAGE_BYTES));
  assign we         = copy_phase && pvalid[slot] && supply_ok;
  assign waddr      = {base, slot};
  assign wdata      = pbuf[slot];
  assign busy       = busy_q;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_prot_eeprom_pkg::*;
#(
  parameter int         ADDR_W     = 11,
  parameter int         PAGE_BYTES = 16,
  parameter logic [3:0] DEV_CODE   = 4'b1010
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sda_f,
  input  logic                                 scl_rise,
  input  logic                                 scl_fall,
  input  logic                                 start_evt,
  input  logic                                 stop_evt,
  input  logic                                 busy,
  input  logic                                 wp,
  input  logic                                 supply_ok,
  input  logic [7:0]                           rdata,
  output logic [ADDR_W-1:0]                    cur_addr,
  output logic                                 prog_start,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic [PAGE_BYTES-1:0][7:0]           pbuf,
  output logic [PAGE_BYTES-1:0]                pvalid,
  output logic                                 sda_pull,
  output logic                                 ack_slot,
  output logic                                 rd_slot,
  output bus_state_t                           state_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int BLK_W = ADDR_W - 8;

  bus_state_t       state_q, next_q;
  logic [3:0]       bits_q;
  logic [7:0]       shreg_q;
  logic [BLK_W-1:0] blk_q;
  logic             pend_q;
  logic             write_ok;

  function automatic logic code_hit(input logic [7:0] b);
    return b[7:4] == DEV_CODE;
  endfunction

  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    logic [OFS_W-1:0] lo;
    lo = a[OFS_W-1:0] + 1'b1;
    return {a[ADDR_W-1:OFS_W], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] seq_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign write_ok = ~wp & supply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      next_q    <= S_IDLE;
      bits_q    <= '0;
      shreg_q   <= '0;
      blk_q     <= '0;
      pend_q    <= 1'b0;
      sda_pull  <= 1'b0;
      cur_addr  <= '0;
      page_base <= '0;
      pbuf      <= '0;
      pvalid    <= '0;
    end else if (start_evt) begin
      pend_q   <= 1'b0;
      sda_pull <= 1'b0;
      bits_q   <= '0;
      state_q  <= busy ? S_IDLE : S_DEV;
    end else if (stop_evt) begin
      pend_q   <= 1'b0;
      sda_pull <= 1'b0;
      state_q  <= S_IDLE;
    end else begin
      case (state_q)
        S_DEV, S_WADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg_q <= {shreg_q[6:0], sda_f};
            bits_q  <= bits_q + 4'd1;
          end else if (scl_fall && bits_q == 4'd8) begin
            bits_q <= '0;
            if (state_q == S_DEV) begin
              if (code_hit(shreg_q)) begin
                blk_q    <= shreg_q[BLK_W:1];
                sda_pull <= 1'b1;
                next_q   <= shreg_q[0] ? S_RD : S_WADDR;
                state_q  <= S_ACK;
              end else begin
                state_q <= S_IDLE;
              end
            end else if (state_q == S_WADDR) begin
              cur_addr  <= {blk_q, shreg_q};
              page_base <= {blk_q, shreg_q[7:OFS_W]};
              pvalid    <= '0;
              sda_pull  <= 1'b1;
              next_q    <= S_WDATA;
              state_q   <= S_ACK;
            end else begin
              pbuf[cur_addr[OFS_W-1:0]]   <= shreg_q;
              pvalid[cur_addr[OFS_W-1:0]] <= 1'b1;
              cur_addr <= page_step(cur_addr);
              pend_q   <= 1'b1;
              sda_pull <= 1'b1;
              next_q   <= S_WDATA;
              state_q  <= S_ACK;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bits_q   <= '0;
            state_q  <= next_q;
            sda_pull <= (next_q == S_RD) ? ~rdata[7] : 1'b0;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bits_q <= bits_q + 4'd1;
          end else if (scl_fall) begin
            if (bits_q == 4'd8) begin
              sda_pull <= 1'b0;
              state_q  <= S_RACK;
            end else begin
              sda_pull <= ~rdata[~bits_q[2:0]];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            cur_addr <= seq_step(cur_addr);
            if (sda_f) begin
              state_q <= S_IDLE;
            end else begin
              next_q  <= S_RD;
              state_q <= S_ACK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign prog_start = stop_evt & pend_q & write_ok;
  assign ack_slot   = (state_q == S_ACK);
  assign rd_slot    = (state_q == S_RD);
  assign state_o    = state_q;
endmodule

// File: rtl/i2c_prot_eeprom.sv
module i2c_prot_eeprom
  import i2c_prot_eeprom_pkg::*;
#(
  parameter int         ADDR_W        = 11,
  parameter int         PAGE_BYTES    = 16,
  parameter int         GLITCH_CYCLES = 20,
  parameter int         PROG_CYCLES   = 1000000,
  parameter logic [3:0] DEV_CODE      = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  input  logic wp_i,
  input  logic supply_ok_i
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFS_W;

  logic [1:0] raw_lines, clean_lines;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, prog_start, mem_we, ack_slot, rd_slot;
  logic [ADDR_W-1:0] cur_addr, mem_waddr;
  logic [7:0] rdata, mem_wdata;
  logic [BASE_W-1:0] page_base;
  logic [PAGE_BYTES-1:0][7:0] pbuf;
  logic [PAGE_BYTES-1:0] pvalid;
  bus_state_t fsm_state;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    sig_filter #(.CYC(GLITCH_CYCLES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (clean_lines[g])
    );
  end

  bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (clean_lines[0]),
    .sda_f    (clean_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  i2c_target_fsm #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DEV_CODE(DEV_CODE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_f     (clean_lines[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .busy      (busy),
    .wp        (wp_i),
    .supply_ok (supply_ok_i),
    .rdata     (rdata),
    .cur_addr  (cur_addr),
    .prog_start(prog_start),
    .page_base (page_base),
    .pbuf      (pbuf),
    .pvalid    (pvalid),
    .sda_pull  (sda_pull_o),
    .ack_slot  (ack_slot),
    .rd_slot   (rd_slot),
    .state_o   (fsm_state)
  );

  prog_engine #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
  ) u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (prog_start),
    .base     (page_base),
    .pbuf     (pbuf),
    .pvalid   (pvalid),
    .supply_ok(supply_ok_i),
    .busy     (busy),
    .we       (mem_we),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata)
  );

  mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(cur_addr),
    .rdata(rdata)
  );
endmodule

// File: rtl/i2c_prot_eeprom_chk.sv
module i2c_prot_eeprom_chk
  import i2c_prot_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       busy,
  input logic       mem_we,
  input logic       start_evt,
  input logic       ack_slot,
  input logic       rd_slot,
  input bus_state_t fsm_state,
  input logic       wp,
  input logic       supply_ok
);
  // R6: line stays released for the whole program window
  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  // R6: a START seen in the window leaves the target idle
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_evt) |=> (fsm_state == S_IDLE));

  // R2: the array is only written inside a program window
  p_write_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R4: a window never opens while the array is protected
  p_no_window_protected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));

  // R5: a window never opens under supply lockout
  p_no_window_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(supply_ok));

  // R10: pulling low only in an acknowledge slot or a read bit
  p_pull_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (ack_slot || rd_slot));
endmodule

bind i2c_prot_eeprom i2c_prot_eeprom_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_pull (sda_pull_o),
  .busy     (busy),
  .mem_we   (mem_we),
  .start_evt(start_evt),
  .ack_slot (ack_slot),
  .rd_slot  (rd_slot),
  .fsm_state(fsm_state),
  .wp       (wp_i),
  .supply_ok(supply_ok_i)
);

// File: tb/i2c_prot_eeprom_bench.sv
`timescale 1ns/1ps
module i2c_prot_eeprom_bench;
  localparam int Q      = 16;
  localparam int GLITCH = 8;
  localparam int PROG   = 400;
  localparam int LIMIT  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_low = 1'b0;
  logic wp = 1'b0;
  logic supply_ok = 1'b1;
  logic sda_pull;
  logic sda_line;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  longint cycles = 0;

  logic [7:0] ref_mem [2048];
  bit         known [2048];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  assign sda_line = ~(host_low | sda_pull);

  always #5 clk = ~clk;

  i2c_prot_eeprom #(
    .GLITCH_CYCLES(GLITCH), .PROG_CYCLES(PROG)
  ) u_i2c_prot_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wp_i(wp), .supply_ok_i(supply_ok)
  );

  function automatic logic [7:0] dev_byte(input int addr, input bit rd);
    return {4'b1010, 3'((addr >> 8) & 7), rd};
  endfunction

  function automatic int page_addr(input int start, input int i);
    return (start & 11'h7F0) | ((start + i) & 15);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start();
    host_low = 1'b1; w(2*Q);
    host_scl = 1'b0; w(Q);
  endtask

  task automatic t_rstart();
    host_low = 1'b0; w(Q);
    host_scl = 1'b1; w(Q);
    host_low = 1'b1; w(Q);
    host_scl = 1'b0; w(Q);
  endtask

  task automatic t_stop();
    host_low = 1'b1; w(Q);
    host_scl = 1'b1; w(Q);
    host_low = 1'b0; w(2*Q);
  endtask

  task automatic t_send(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; w(Q);
      host_scl = 1'b1; w(Q);
      if (glitch && i == 2) begin
        host_low = ~host_low; w(GLITCH/2);
        host_low = ~host_low; w(Q - GLITCH/2);
      end else begin
        w(Q);
      end
      host_scl = 1'b0;
      if (glitch && i == 4) begin
        w(Q/2); host_scl = 1'b1; w(GLITCH/2); host_scl = 1'b0; w(Q/2 - GLITCH/2);
      end else begin
        w(Q);
      end
    end
    host_low = 1'b0; w(Q);
    host_scl = 1'b1; w(Q);
    ack = ~sda_line; w(Q);
    host_scl = 1'b0; w(Q);
  endtask

  task automatic t_recv(input bit give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(Q);
      host_scl = 1'b1; w(Q);
      b[i] = sda_line; w(Q);
      host_scl = 1'b0; w(Q);
    end
    host_low = give_ack; w(Q);
    host_scl = 1'b1; w(2*Q);
    host_scl = 1'b0; w(Q);
    host_low = 1'b0;
  endtask

  task automatic probe(output bit ack);
    bit a;
    t_start(); t_send(dev_byte(0, 1'b0), 1'b0, a); t_stop();
    ack = a;
  endtask

  // write n bytes from wbuf; returns the count of data bytes acknowledged
  task automatic wr_txn(input int addr, input int n, input bit glitch, output int acked);
    bit a;
    acked = 0;
    t_start();
    t_send(dev_byte(addr, 1'b0), 1'b0, a);
    t_send(8'(addr), 1'b0, a);
    for (int i = 0; i < n; i++) begin
      t_send(wbuf[i], glitch, a);
      if (a) acked++;
    end
    t_stop();
  endtask

  task automatic rd_txn(input int addr, input int n);
    bit a;
    t_start();
    t_send(dev_byte(addr, 1'b0), 1'b0, a);
    t_send(8'(addr), 1'b0, a);
    t_rstart();
    t_send(dev_byte(addr, 1'b1), 1'b0, a);
    for (int i = 0; i < n; i++) t_recv(i != n - 1, rbuf[i]);
    t_stop();
  endtask

  task automatic ref_commit(input int addr, input int n);
    for (int i = 0; i < n; i++) begin
      ref_mem[page_addr(addr, i)] = wbuf[i];
      known[page_addr(addr, i)]   = 1'b1;
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > LIMIT) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cycles, LIMIT);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    bit a;
    int acked;
    logic [7:0] b;
    void'($urandom(32'd7321));
    for (int i = 0; i < 2048; i++) known[i] = 1'b0;
    w(10);
    chk("R10 reset release", int'(sda_pull), 0);
    rst_n = 1'b1;
    w(50);
    chk("R10 idle release", int'(sda_pull), 0);

    // R1: wrong code is refused and the following byte too
    t_start();
    t_send(8'hB0, 1'b0, a); chk("R1 wrong code nack", int'(a), 0);
    t_send(8'hA0, 1'b0, a); chk("R1 ignored until START", int'(a), 0);
    t_stop();
    probe(a); chk("R1 code match ack", int'(a), 1);

    // R2 byte write, R6 window, R7 random read
    wbuf[0] = 8'hA5;
    wr_txn(11'h123, 1, 1'b0, acked);
    chk("R2 data ack", acked, 1);
    probe(a); chk("R6 nack in window", int'(a), 0);
    w(PROG + 100);
    probe(a); chk("R6 ack after window", int'(a), 1);
    ref_commit(11'h123, 1);
    rd_txn(11'h123, 1);
    chk("R2 R7 read back", int'(rbuf[0]), int'(ref_mem[11'h123]));

    // R3 page overflow: 18 bytes from offset 5
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h40 + i);
    wr_txn(11'h235, 18, 1'b0, acked);
    chk("R3 all data acked", acked, 18);
    w(PROG + 100);
    ref_commit(11'h235, 18);
    rd_txn(11'h230, 16);
    for (int i = 0; i < 16; i++)
      chk($sformatf("R3 R9 page byte %0d", i), int'(rbuf[i]), int'(ref_mem[11'h230 + i]));
    chk("R3 overwrite offset5", int'(rbuf[5]), 8'h50);

    // R4 write protect
    wp = 1'b1;
    wbuf[0] = 8'h11;
    wr_txn(11'h123, 1, 1'b0, acked);
    chk("R4 protected data acked", acked, 1);
    probe(a); chk("R4 no window", int'(a), 1);
    wp = 1'b0;
    rd_txn(11'h123, 1);
    chk("R4 memory kept", int'(rbuf[0]), 8'hA5);

    // R5 supply lockout
    supply_ok = 1'b0;
    wbuf[0] = 8'h22;
    wr_txn(11'h123, 1, 1'b0, acked);
    chk("R5 lockout data acked", acked, 1);
    probe(a); chk("R5 no window", int'(a), 1);
    supply_ok = 1'b1;
    rd_txn(11'h123, 1);
    chk("R5 memory kept", int'(rbuf[0]), 8'hA5);

    // R12 repeated START before STOP discards data
    t_start();
    t_send(dev_byte(11'h123, 1'b0), 1'b0, a);
    t_send(8'h23, 1'b0, a);
    t_send(8'h33, 1'b0, a);
    t_rstart();
    t_send(dev_byte(11'h123, 1'b0), 1'b0, a);
    t_send(8'h23, 1'b0, a);
    t_stop();
    probe(a); chk("R12 no window", int'(a), 1);
    rd_txn(11'h123, 1);
    chk("R12 memory kept", int'(rbuf[0]), 8'hA5);

    // R9 wrap 2047 -> 0, then R8 current-address read
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    wr_txn(11'h7FE, 2, 1'b0, acked); w(PROG + 100); ref_commit(11'h7FE, 2);
    wbuf[0] = 8'hD1; wbuf[1] = 8'hD2;
    wr_txn(11'h000, 2, 1'b0, acked); w(PROG + 100); ref_commit(11'h000, 2);
    rd_txn(11'h7FE, 3);
    chk("R9 byte 2046", int'(rbuf[0]), int'(ref_mem[2046]));
    chk("R9 byte 2047", int'(rbuf[1]), int'(ref_mem[2047]));
    chk("R9 wrap to 0", int'(rbuf[2]), int'(ref_mem[0]));
    t_start();
    t_send(dev_byte(0, 1'b1), 1'b0, a);
    chk("R8 read addr ack", int'(a), 1);
    t_recv(1'b0, b);
    t_stop();
    chk("R8 current address", int'(b), int'(ref_mem[1]));
    chk("R9 released after nack", int'(sda_pull), 0);

    // R11 spikes on SCL and SDA inside a data byte
    wbuf[0] = 8'h5E;
    wr_txn(11'h300, 1, 1'b1, acked);
    chk("R11 glitched byte acked", acked, 1);
    w(PROG + 100);
    ref_commit(11'h300, 1);
    rd_txn(11'h300, 1);
    chk("R11 glitched byte stored", int'(rbuf[0]), int'(ref_mem[11'h300]));

    // random page writes with random protection, each probed then read back
    for (int it = 0; it < 4; it++) begin
      int addr, n, mode;
      bit allowed;
      addr = int'($urandom_range(0, 2047));
      n    = int'($urandom_range(1, 16));
      mode = int'($urandom_range(0, 3));
      wp        = (mode == 0);
      supply_ok = (mode != 1);
      allowed   = (mode >= 2);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_txn(addr, n, 1'b0, acked);
      chk("R4 R5 random data acked", acked, n);
      wp = 1'b0; supply_ok = 1'b1;
      probe(a);
      chk("R6 random probe", int'(a), allowed ? 0 : 1);
      if (allowed) begin
        w(PROG + 100);
        ref_commit(addr, n);
      end
      rd_txn(addr, n);
      for (int i = 0; i < n; i++) begin
        int ra;
        ra = (addr + i) & 2047;
        if (known[ra]) chk($sformatf("R2 R3 random read %0h", ra), int'(rbuf[i]), int'(ref_mem[ra]));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule